// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block is the combinational control logic for a five-stage in-order pipeline. It has no state of its own. Each cycle it looks at the register fields held in the pipeline registers and decides four things:

- whether the program counter and the fetch/decode register may advance;
- whether a bubble goes into the decode/execute register;
- where each of the two execute-stage operands gets its value;
- whether wrong-path instructions are discarded after a taken branch or jump.

A global pipeline enable is combined into the advance signal. A consumer that directly follows a load is held for exactly one cycle. After that cycle the loaded value reaches the consumer through the memory/writeback bypass. A result from any other producer is bypassed straight from the execute/memory register, so no cycle is lost. This covers an ALU result that feeds a store's data operand.

The surrounding datapath is expected to do four things with the outputs:

- use `fetch_en` as the load enable of the PC and of the fetch/decode register;
- clear the control fields of the decode/execute register when `dx_bubble` or `dx_flush` is high;
- clear the fetch/decode register when `fd_flush` is high;
- steer its execute-stage operand multiplexers with the two select codes.

Top module: `hz_pipe_ctrl`

## Requirements
- R1: `fetch_en` is high only when `pipe_en` is high and no load-use stall is being taken. With no load-use match and no taken branch, `fetch_en` equals `pipe_en`.
- R2: A load-use stall needs four conditions at once: the execute-stage instruction is a load (`ex_is_load`=1), it writes a register (`ex_wr_en`=1), its destination `ex_rd` is not zero, and `ex_rd` equals `dec_rs1` or `dec_rs2`. The stall drives `fetch_en` low and `dx_bubble` high for that input combination only, so the hold lasts one cycle.
- R3: A matching producer in execute that is not a load never causes a stall. `dx_bubble` stays 0 and `fetch_en` follows `pipe_en`.
- R4: An operand select is 2'b10 (execute/memory result) when `exm_wr_en`=1, `exm_rd`≠0 and `exm_rd` equals that operand's source index. This includes the data operand of a store.
- R5: An operand select is 2'b01 (memory/writeback result) when `mwb_wr_en`=1, `mwb_rd`≠0, `mwb_rd` equals the source, and the execute/memory stage does not match. This is the path a load's value takes to its consumer after the one-cycle stall.
- R6: When both forwarding stages match the same source, the select is 2'b10. The younger result wins.
- R7: A producer whose destination is 0 or whose write enable is low is never forwarded from, and it never causes a stall. With no valid match the select is 2'b00 (register file).
- R8: `fd_flush` and `dx_flush` are high exactly when `ex_br_taken` is high.
- R9: A flush overrides a stall. With `ex_br_taken`=1 and a load-use match present, `dx_bubble` is 0 and `fetch_en` equals `pipe_en`.
- R10: The two operand selects are decided independently. `fwd_sel_a` depends only on `ex_rs1`, and `fwd_sel_b` depends only on `ex_rs2`.
- R11: `pipe_en` affects only `fetch_en`. The operand selects, flushes and bubble do not depend on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pipe_en | input | 1 | Global pipeline enable |
| dec_rs1 | input | IDX_W | First source index of the instruction in decode |
| dec_rs2 | input | IDX_W | Second source index of the instruction in decode |
| ex_rs1 | input | IDX_W | First source index of the instruction in execute |
| ex_rs2 | input | IDX_W | Second source index of the instruction in execute |
| ex_rd | input | IDX_W | Destination index of the instruction in execute |
| ex_wr_en | input | 1 | Instruction in execute writes a register |
| ex_is_load | input | 1 | Instruction in execute is a load |
| exm_rd | input | IDX_W | Destination index held in the execute/memory register |
| exm_wr_en | input | 1 | Register write enable held in the execute/memory register |
| mwb_rd | input | IDX_W | Destination index held in the memory/writeback register |
| mwb_wr_en | input | 1 | Register write enable held in the memory/writeback register |
| ex_br_taken | input | 1 | Branch or jump in execute resolved taken |
| fetch_en | output | 1 | Load enable for the PC and the fetch/decode register |
| dx_bubble | output | 1 | Load a no-op into the decode/execute register |
| fd_flush | output | 1 | Clear the fetch/decode register |
| dx_flush | output | 1 | Clear the decode/execute register |
| fwd_sel_a | output | 2 | First operand source: 00 register file, 01 memory/writeback, 10 execute/memory |
| fwd_sel_b | output | 2 | Second operand source, same encoding |

## Verification
Two situations let functions of this block meet in the same cycle.

The first is a taken branch in the same cycle as a load-use match. The bench drives a load whose destination matches a decode source while `ex_br_taken` is high. It expects both flushes, no bubble, and `fetch_en` following `pipe_en`. So the flush alone decides the cycle.

The second is both forwarding stages matching one operand. Here the bench expects the execute/memory code. It also disables the younger stage, through its write enable or by naming register zero, and expects the older match to win instead.

// File: rtl/hz_pipe_pkg.sv
// Package: shared types for the pipeline hazard and forwarding control.
// Assumes two-bit operand source codes decoded by the execute-stage muxes.
package hz_pipe_pkg;

    // Width of an operand source select code
    localparam int unsigned FWD_SEL_W = 2;

    // Operand source for an execute-stage input
    typedef enum logic [FWD_SEL_W-1:0] {
        FWD_RF    = 2'b00,   // value read from the register file in decode
        FWD_MEMWB = 2'b01,   // result held in the memory/writeback register
        FWD_EXMEM = 2'b10    // result held in the execute/memory register
    } fwd_sel_e;

endpackage

// File: rtl/hz_fwd_select.sv
// Module: hz_fwd_select
// Picks the source of one execute-stage operand by comparing its register
// index with the destinations held in the two later pipeline registers.
// Assumes register index 0 is hard-wired to zero and is never a producer.
module hz_fwd_select
    import hz_pipe_pkg::*;
#(
    parameter int unsigned IDX_W = 5
) (
    input  logic [IDX_W-1:0] src_idx,
    input  logic [IDX_W-1:0] exm_rd,
    input  logic             exm_wr_en,
    input  logic [IDX_W-1:0] mwb_rd,
    input  logic             mwb_wr_en,
    output fwd_sel_e         sel
);

    localparam logic [IDX_W-1:0] ZERO_IDX = '0;

    logic exm_hit;
    logic mwb_hit;

    // Match against each producer, excluding register zero and non-writers
    always_comb begin
        exm_hit = exm_wr_en && (exm_rd != ZERO_IDX) && (exm_rd == src_idx);
        mwb_hit = mwb_wr_en && (mwb_rd != ZERO_IDX) && (mwb_rd == src_idx);
    end

    // Priority choice: younger execute/memory result before memory/writeback
    always_comb begin
        if (exm_hit) begin
            sel = FWD_EXMEM;
        end else if (mwb_hit) begin
            sel = FWD_MEMWB;
        end else begin
            sel = FWD_RF;
        end
    end

    // Checks tying the chosen code back to the producer fields
    always_comb begin
        // R6
        exm_prio_chk: assert (!(exm_wr_en && exm_rd != ZERO_IDX && exm_rd == src_idx)
                              || sel == FWD_EXMEM)
            else $error("exm match not forwarded");
        // R7
        mwb_valid_chk: assert (sel != FWD_MEMWB
                               || (mwb_wr_en && mwb_rd != ZERO_IDX && mwb_rd == src_idx))
            else $error("mwb select without valid producer");
        // R7
        exm_valid_chk: assert (sel != FWD_EXMEM
                               || (exm_wr_en && exm_rd != ZERO_IDX))
            else $error("exm select without valid producer");
    end

endmodule

// File: rtl/hz_load_use_det.sv
// Module: hz_load_use_det
// Flags a load in execute whose destination is read by the instruction in
// decode. Assumes load data becomes usable only after the memory stage.
module hz_load_use_det #(
    parameter int unsigned IDX_W = 5
) (
    input  logic [IDX_W-1:0] dec_rs1,
    input  logic [IDX_W-1:0] dec_rs2,
    input  logic [IDX_W-1:0] ex_rd,
    input  logic             ex_wr_en,
    input  logic             ex_is_load,
    output logic             lu_hit
);

    localparam logic [IDX_W-1:0] ZERO_IDX = '0;

    logic src_match;

    // Either decode source names the load destination
    always_comb begin
        src_match = (ex_rd == dec_rs1) || (ex_rd == dec_rs2);
    end

    // Hazard only for a real load writing a nonzero register
    always_comb begin
        lu_hit = ex_is_load && ex_wr_en && (ex_rd != ZERO_IDX) && src_match;
    end

    // Checks on the detect output against its inputs
    always_comb begin
        // R3
        lu_load_only_chk: assert (!lu_hit || ex_is_load)
            else $error("load-use flagged for non-load");
        // R7
        lu_zero_chk: assert (!lu_hit || (ex_wr_en && ex_rd != ZERO_IDX))
            else $error("load-use flagged for x0 or non-writer");
    end

endmodule

// File: rtl/hz_stall_flush.sv
// Module: hz_stall_flush
// Combines the global enable, the load-use detect and the taken-branch flag
// into the fetch enable, bubble and flush controls. Assumes a taken branch
// redirects fetch, so a stall in the same cycle is dropped.
module hz_stall_flush (
    input  logic pipe_en,
    input  logic lu_hit,
    input  logic br_taken,
    output logic fetch_en,
    output logic dx_bubble,
    output logic fd_flush,
    output logic dx_flush
);

    logic take_stall;

    // A stall is only taken when no flush claims the cycle
    always_comb begin
        take_stall = lu_hit && !br_taken;
    end

    // Fetch advances when enabled and not held; bubble fills the gap
    always_comb begin
        fetch_en  = pipe_en && !take_stall;
        dx_bubble = take_stall;
    end

    // Wrong-path instructions in both early registers are discarded
    always_comb begin
        fd_flush = br_taken;
        dx_flush = br_taken;
    end

    // Checks on the relations between the control outputs
    always_comb begin
        // R1
        fetch_gate_chk: assert (!fetch_en || pipe_en)
            else $error("fetch enabled while pipeline disabled");
        // R2
        bubble_hold_chk: assert (!dx_bubble || !fetch_en)
            else $error("bubble inserted while fetch advances");
        // R9
        flush_over_stall_chk: assert (!(dx_bubble && fd_flush))
            else $error("bubble and flush together");
        // R9
        flush_fetch_chk: assert (!br_taken || fetch_en == pipe_en)
            else $error("fetch held during flush");
    end

endmodule

// File: rtl/hz_pipe_ctrl.sv
// Module: hz_pipe_ctrl (top)
// Hazard and forwarding control for a five-stage in-order pipeline.
// Purely combinational: it compares the register fields of the pipeline
// registers and drives the fetch enable, bubble, flush and operand selects.
// Assumes the datapath applies these outputs on its next clock edge.
module hz_pipe_ctrl
    import hz_pipe_pkg::*;
#(
    parameter int unsigned IDX_W  = 5,
    parameter int unsigned N_OPER = 2
) (
    input  logic             pipe_en,
    input  logic [IDX_W-1:0] dec_rs1,
    input  logic [IDX_W-1:0] dec_rs2,
    input  logic [IDX_W-1:0] ex_rs1,
    input  logic [IDX_W-1:0] ex_rs2,
    input  logic [IDX_W-1:0] ex_rd,
    input  logic             ex_wr_en,
    input  logic             ex_is_load,
    input  logic [IDX_W-1:0] exm_rd,
    input  logic             exm_wr_en,
    input  logic [IDX_W-1:0] mwb_rd,
    input  logic             mwb_wr_en,
    input  logic             ex_br_taken,
    output logic             fetch_en,
    output logic             dx_bubble,
    output logic             fd_flush,
    output logic             dx_flush,
    output logic [1:0]       fwd_sel_a,
    output logic [1:0]       fwd_sel_b
);

    logic [IDX_W-1:0] oper_src [N_OPER];
    fwd_sel_e         oper_sel [N_OPER];
    logic             lu_hit;

    // Gather the execute-stage source indices into one array
    always_comb begin
        oper_src[0] = ex_rs1;
        oper_src[1] = ex_rs2;
    end

    // One forwarding selector per execute-stage operand
    for (genvar gi = 0; gi < N_OPER; gi++) begin : g_oper
        hz_fwd_select #(
            .IDX_W(IDX_W)
        ) fwd_sel_i (
            .src_idx  (oper_src[gi]),
            .exm_rd   (exm_rd),
            .exm_wr_en(exm_wr_en),
            .mwb_rd   (mwb_rd),
            .mwb_wr_en(mwb_wr_en),
            .sel      (oper_sel[gi])
        );
    end

    // Present the operand codes as plain vectors
    always_comb begin
        fwd_sel_a = oper_sel[0];
        fwd_sel_b = oper_sel[1];
    end

    hz_load_use_det #(
        .IDX_W(IDX_W)
    ) lu_det_i (
        .dec_rs1   (dec_rs1),
        .dec_rs2   (dec_rs2),
        .ex_rd     (ex_rd),
        .ex_wr_en  (ex_wr_en),
        .ex_is_load(ex_is_load),
        .lu_hit    (lu_hit)
    );

    hz_stall_flush stall_flush_i (
        .pipe_en  (pipe_en),
        .lu_hit   (lu_hit),
        .br_taken (ex_br_taken),
        .fetch_en (fetch_en),
        .dx_bubble(dx_bubble),
        .fd_flush (fd_flush),
        .dx_flush (dx_flush)
    );

    // Top-level checks across the port boundary
    always_comb begin
        // R8
        flush_pair_chk: assert (fd_flush == dx_flush && fd_flush == ex_br_taken)
            else $error("flush outputs disagree with branch flag");
        // R3
        alu_no_stall_chk: assert (ex_is_load || !dx_bubble)
            else $error("bubble without load in execute");
    end

endmodule

// File: tb/hz_pipe_ctrl_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies a vector and queues its expected
// outputs; the monitor pops and compares at the following falling edge.
module hz_pipe_ctrl_tb_top;

    localparam int unsigned IDX_W = 5;

    typedef struct {
        logic             en;
        logic [IDX_W-1:0] drs1, drs2, ers1, ers2, erd, xrd, wrd;
        logic             ewe, eld, xwe, wwe, br;
    } stim_t;

    typedef struct {
        logic       fen, bub, ffl, dfl;
        logic [1:0] fa, fb;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic             pipe_en, ex_wr_en, ex_is_load, exm_wr_en, mwb_wr_en, ex_br_taken;
    logic [IDX_W-1:0] dec_rs1, dec_rs2, ex_rs1, ex_rs2, ex_rd, exm_rd, mwb_rd;
    logic             fetch_en, dx_bubble, fd_flush, dx_flush;
    logic [1:0]       fwd_sel_a, fwd_sel_b;

    hz_pipe_ctrl #(.IDX_W(IDX_W)) dut_i (
        .pipe_en(pipe_en), .dec_rs1(dec_rs1), .dec_rs2(dec_rs2),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd),
        .ex_wr_en(ex_wr_en), .ex_is_load(ex_is_load),
        .exm_rd(exm_rd), .exm_wr_en(exm_wr_en),
        .mwb_rd(mwb_rd), .mwb_wr_en(mwb_wr_en),
        .ex_br_taken(ex_br_taken),
        .fetch_en(fetch_en), .dx_bubble(dx_bubble),
        .fd_flush(fd_flush), .dx_flush(dx_flush),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b)
    );

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    // Expected operand code from R4..R7
    function automatic logic [1:0] exp_fwd(input stim_t s, input logic [IDX_W-1:0] src);
        if (s.xwe && s.xrd != 0 && s.xrd == src) return 2'b10;
        if (s.wwe && s.wrd != 0 && s.wrd == src) return 2'b01;
        return 2'b00;
    endfunction

    // Expected outputs from the requirements
    function automatic exp_t model(input stim_t s, input string tag);
        exp_t e;
        logic hazard;
        hazard = s.eld && s.ewe && (s.erd != 0) && (s.erd == s.drs1 || s.erd == s.drs2);
        if (s.br) hazard = 1'b0;                 // R9
        e.fen = s.en && !hazard;                 // R1
        e.bub = hazard;                          // R2
        e.ffl = s.br;                            // R8
        e.dfl = s.br;
        e.fa  = exp_fwd(s, s.ers1);              // R10
        e.fb  = exp_fwd(s, s.ers2);
        e.tag = tag;
        return e;
    endfunction

    // Driver: apply one vector after a rising edge and queue its expectation
    task automatic drive(input stim_t s, input string tag);
        @(posedge clk);
        pipe_en = s.en; dec_rs1 = s.drs1; dec_rs2 = s.drs2;
        ex_rs1 = s.ers1; ex_rs2 = s.ers2; ex_rd = s.erd;
        ex_wr_en = s.ewe; ex_is_load = s.eld;
        exm_rd = s.xrd; exm_wr_en = s.xwe;
        mwb_rd = s.wrd; mwb_wr_en = s.wwe; ex_br_taken = s.br;
        sb_q.push_back(model(s, tag));
    endtask

    task automatic cmp(input string tag, input string fld, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, fld, act, exp);
        end
    endtask

    // Monitor: compare outputs at the falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            cmp(e.tag, "fetch_en",  {1'b0, fetch_en},  {1'b0, e.fen});
            cmp(e.tag, "dx_bubble", {1'b0, dx_bubble}, {1'b0, e.bub});
            cmp(e.tag, "fd_flush",  {1'b0, fd_flush},  {1'b0, e.ffl});
            cmp(e.tag, "dx_flush",  {1'b0, dx_flush},  {1'b0, e.dfl});
            cmp(e.tag, "fwd_sel_a", fwd_sel_a, e.fa);
            cmp(e.tag, "fwd_sel_b", fwd_sel_b, e.fb);
        end
    end

    function automatic stim_t idle();
        stim_t s;
        s.en = 1'b1; s.drs1 = '0; s.drs2 = '0; s.ers1 = '0; s.ers2 = '0;
        s.erd = '0; s.xrd = '0; s.wrd = '0;
        s.ewe = 1'b0; s.eld = 1'b0; s.xwe = 1'b0; s.wwe = 1'b0; s.br = 1'b0;
        return s;
    endfunction

    initial begin
        stim_t s;
        pipe_en = 1'b1; dec_rs1 = '0; dec_rs2 = '0; ex_rs1 = '0; ex_rs2 = '0;
        ex_rd = '0; ex_wr_en = 1'b0; ex_is_load = 1'b0; exm_rd = '0;
        exm_wr_en = 1'b0; mwb_rd = '0; mwb_wr_en = 1'b0; ex_br_taken = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1 idle state: fetch follows enable, register file operands
        s = idle(); drive(s, "R1_idle");
        // R11 enable low only drops fetch
        s = idle(); s.en = 1'b0; drive(s, "R11_disabled");
        // R2 load-use on first decode source
        s = idle(); s.eld = 1; s.ewe = 1; s.erd = 5'd5; s.drs1 = 5'd5; drive(s, "R2_lu_rs1");
        // R2 load-use on second decode source
        s = idle(); s.eld = 1; s.ewe = 1; s.erd = 5'd9; s.drs2 = 5'd9; s.drs1 = 5'd3; drive(s, "R2_lu_rs2");
        // R2 next cycle: load gone from execute, no hold
        s = idle(); s.drs1 = 5'd5; drive(s, "R2_one_cycle");
        // R7 load to register zero never stalls
        s = idle(); s.eld = 1; s.ewe = 1; s.erd = 5'd0; drive(s, "R7_lu_x0");
        // R3 ALU producer matching decode does not stall
        s = idle(); s.ewe = 1; s.erd = 5'd7; s.drs1 = 5'd7; drive(s, "R3_alu_match");
        // R4 ALU result to store data operand from execute/memory
        s = idle(); s.xwe = 1; s.xrd = 5'd11; s.ers2 = 5'd11; s.ers1 = 5'd2; drive(s, "R4_store_data");
        // R5 loaded value reaches consumer from memory/writeback after stall
        s = idle(); s.wwe = 1; s.wrd = 5'd5; s.ers1 = 5'd5; s.ers2 = 5'd5; drive(s, "R5_after_lu");
        // R6 both stages match, younger wins
        s = idle(); s.xwe = 1; s.xrd = 5'd4; s.wwe = 1; s.wrd = 5'd4; s.ers1 = 5'd4; drive(s, "R6_priority");
        // R7 younger write disabled, older wins
        s = idle(); s.xwe = 0; s.xrd = 5'd4; s.wwe = 1; s.wrd = 5'd4; s.ers1 = 5'd4; drive(s, "R7_we_low");
        // R7 register zero never forwarded
        s = idle(); s.xwe = 1; s.xrd = 5'd0; s.wwe = 1; s.wrd = 5'd0; drive(s, "R7_x0");
        // R8 taken branch flushes both registers
        s = idle(); s.br = 1; drive(s, "R8_flush");
        // R9 flush over load-use stall
        s = idle(); s.br = 1; s.eld = 1; s.ewe = 1; s.erd = 5'd6; s.drs2 = 5'd6; drive(s, "R9_flush_lu");
        // R9 same with pipeline disabled
        s = idle(); s.en = 0; s.br = 1; s.eld = 1; s.ewe = 1; s.erd = 5'd6; s.drs1 = 5'd6; drive(s, "R9_flush_dis");
        // R10 operands pick different stages
        s = idle(); s.xwe = 1; s.xrd = 5'd12; s.wwe = 1; s.wrd = 5'd13; s.ers1 = 5'd13; s.ers2 = 5'd12; drive(s, "R10_split");
        // R11 disabled pipeline keeps forwarding codes
        s = idle(); s.en = 0; s.xwe = 1; s.xrd = 5'd8; s.ers1 = 5'd8; s.wwe = 1; s.wrd = 5'd9; s.ers2 = 5'd9; drive(s, "R11_fwd_dis");
        // Sweep over a small index range covering mixed cases
        for (int i = 0; i < 200; i++) begin
            s.en   = i[0];
            s.br   = (i % 7) == 3;
            s.eld  = i[1];
            s.ewe  = (i % 5) != 0;
            s.xwe  = (i % 3) != 0;
            s.wwe  = i[2];
            s.erd  = IDX_W'(i % 4);
            s.drs1 = IDX_W'((i / 4) % 4);
            s.drs2 = IDX_W'((i / 3) % 4);
            s.xrd  = IDX_W'((i / 2) % 4);
            s.wrd  = IDX_W'((i / 5) % 4);
            s.ers1 = IDX_W'((i / 7) % 4);
            s.ers2 = IDX_W'((i / 11) % 4);
            drive(s, "R10_sweep");
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule